// File: doc/BRIEF.md
# Serial-Parallel Signed Multiplier

This block multiplies two signed two's-complement words, one held in parallel and one delivered as a serial bit stream. When a frame starts, the block captures a W-bit parallel operand, such as a neuron activation or a network input. The second operand, such as a synaptic weight, then enters one bit per clock with its least significant bit first. The full 2W-bit signed product leaves on a single output pin, one bit per clock, also least significant bit first. A downstream bit-serial adder can consume this stream directly.

The datapath is a row of 2W identical cells, and the parallel operand is sign-extended across all of them. Each cell gates its operand bit with the current serial bit and passes the result through an XOR. It then adds that term to the sum from its left neighbour and to its own stored carry, using a full adder and two flip-flops. A frame controller drives the XOR inputs. For the serial operand's sign bit, which carries negative weight, the controller inverts every partial product. The matching +1 is placed in the sum chain when the frame is loaded.

Each frame lasts 2W+2 clocks. A new frame may start in the clock right after the previous frame ends, so the output stream of one product overlaps the input of the next.

Top module: `spmul_serial`

## Requirements
- R1: For a parallel operand A and a serial operand B, both W-bit two's complement, the 2W output bits of a frame form the two's-complement value of A*B, least significant bit first.
- R2: A frame starts at the rising edge E0 where `start_i` is accepted, and `opnd_i` is captured at that same edge. Serial bit j of B (j = 0 for the LSB) is sampled at edge E0+1+j, for j from 0 to W-1.
- R3: Product bit k, for k from 0 to 2W-1, is present on `prod_o` from edge E0+W+2+k until the next edge. The LSB latency is therefore W+2 clocks.
- R4: A frame occupies edges E0 to E0+2W+1. A start at edge E0+2W+2, or at any later edge with no frame active, is accepted, so products can be issued back to back with a period of 2W+2.
- R5: `start_i` is ignored at edges E0+1 to E0+2W+1. It neither starts a new frame nor disturbs the product of the running frame.
- R6: `ser_i` is ignored at every edge other than E0+1 to E0+W of an active frame.
- R7: `opnd_i` is ignored at every edge other than an accepted start. Changing it during a frame has no effect on that frame's product.
- R8: `prod_o` is 0 during reset and in every clock that carries no product bit. This includes the clocks after reset before the first product.
- R9: Operands at the most negative value give exact results with no overflow. For example, -32768 * -32768 gives 0x40000000, and -32768 * 32767 gives 0xC0008000 when W = 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start strobe, honoured only when no frame is active |
| opnd_i | input | W | Parallel two's-complement operand, captured at an accepted start |
| ser_i | input | 1 | Serial two's-complement operand, LSB first |
| prod_o | output | 1 | Serial 2W-bit product, LSB first, registered |

## Verification
The first group of operands covers the sign corners: the most negative value against itself and against the largest positive value, -1 against -1, and zero. These separate a correct inversion of the sign-bit row from a missing or misplaced +1 correction. A single-bit operand against a serial word with both end bits set shows whether the serial bits are sampled at the right edges. Random operand pairs run both with idle gaps and back to back, which exposes state left over from the previous frame. During every frame, the serial pin outside the accepted window and the operand pin after capture carry random values, and some frames also carry stray start strobes. A product that still matches shows that these inputs are ignored. Every clock outside a product window is checked for a zero output.

// File: rtl/spmul_pkg.sv
package spmul_pkg;

  // Control word issued by the frame controller to the cell row
  typedef struct packed {
    logic load;    // accepted start: capture operand, clear row, preload correction
    logic step;    // cell row advances one bit time
    logic take;    // serial input bit is part of the operand
    logic negate;  // sign-bit row: invert every partial product
  } spm_ctl_t;

  function automatic int frame_cycles(input int w);
    return 2 * w + 2;
  endfunction

  function automatic int lsb_latency(input int w);
    return w + 2;
  endfunction

endpackage

// File: rtl/spmul_ctrl.sv
module spmul_ctrl
  import spmul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start_i,
  output spm_ctl_t ctl_o
);

  localparam int F  = frame_cycles(W);
  localparam int CW = $clog2(F);
  localparam logic [CW-1:0] STEPS  = CW'(2 * W);
  localparam logic [CW-1:0] TAKEN  = CW'(W);
  localparam logic [CW-1:0] NEG_AT = CW'(W - 1);
  localparam logic [CW-1:0] LAST   = CW'(F - 2);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    ctl_o.load   = start_i & ~run_q;
    ctl_o.step   = run_q && (cnt_q < STEPS);
    ctl_o.take   = run_q && (cnt_q < TAKEN);
    ctl_o.negate = run_q && (cnt_q == NEG_AT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (ctl_o.load) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spmul_cell.sv
module spmul_cell #(
  parameter bit S_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  input  logic a_i,
  input  logic b_i,
  input  logic neg_i,
  input  logic s_i,
  output logic s_o
);

  logic c_q;
  logic pp;
  logic sum;
  logic cout;

  always_comb begin
    pp   = (a_i & b_i) ^ neg_i;
    sum  = pp ^ s_i ^ c_q;
    cout = (pp & s_i) | (pp & c_q) | (s_i & c_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_o <= 1'b0;
      c_q <= 1'b0;
    end else if (clr_i) begin
      s_o <= S_INIT;
      c_q <= 1'b0;
    end else if (en_i) begin
      s_o <= sum;
      c_q <= cout;
    end else begin
      s_o <= 1'b0;
    end
  end

endmodule

// File: rtl/spmul_align.sv
module spmul_align #(
  parameter int DEPTH = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[DEPTH-2:0], d_i};
  end

  assign q_o = sh_q[DEPTH-1];

endmodule

// File: rtl/spmul_serial.sv
module spmul_serial
  import spmul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] opnd_i,
  input  logic         ser_i,
  output logic         prod_o
);

  localparam int CELLS = 2 * W;
  localparam int ALIGN = lsb_latency(W) - 1;

  spm_ctl_t       ctl;
  logic [W-1:0]   opnd_q;
  logic [CELLS:0] s_w;
  logic           b_bit;

  spmul_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .ctl_o   (ctl)
  );

  always_ff @(posedge clk) begin
    if (rst)           opnd_q <= '0;
    else if (ctl.load) opnd_q <= opnd_i;
  end

  assign b_bit      = ser_i & ctl.take;
  assign s_w[CELLS] = 1'b0;

  for (genvar j = 0; j < CELLS; j++) begin : g_cell
    localparam int AI = (j < W) ? j : W - 1;
    spmul_cell #(.S_INIT(j == W)) u_cell (
      .clk   (clk),
      .rst   (rst),
      .clr_i (ctl.load),
      .en_i  (ctl.step),
      .a_i   (opnd_q[AI]),
      .b_i   (b_bit),
      .neg_i (ctl.negate),
      .s_i   (s_w[j+1]),
      .s_o   (s_w[j])
    );
  end

  spmul_align #(.DEPTH(ALIGN)) u_align (
    .clk (clk),
    .rst (rst),
    .d_i (s_w[0]),
    .q_o (prod_o)
  );

endmodule

// File: rtl/spmul_serial_chk.sv
module spmul_serial_chk
  import spmul_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         prod_o,
  input spm_ctl_t     ctl_i,
  input logic         lsb_i,
  input logic [W-1:0] opnd_q
);

  localparam int F   = frame_cycles(W);
  localparam int LAT = lsb_latency(W);

  logic        seen_q;
  logic [15:0] gap_q;
  logic [7:0]  rsince_q;
  logic        acc;

  assign acc = start_i && (!seen_q || gap_q >= 16'(F - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      gap_q    <= '0;
      rsince_q <= '0;
    end else begin
      if (rsince_q != 8'hFF) rsince_q <= rsince_q + 1'b1;
      if (acc) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else if (gap_q != 16'hFFFF) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R4 / R5: a start is taken exactly when no frame is active
  p_load_match_r4: assert property (@(posedge clk) disable iff (rst)
    ctl_i.load == acc);

  // R5: a start during a frame leaves no trace
  p_load_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (start_i && seen_q && gap_q < 16'(F - 1)) |-> !ctl_i.load);

  // R7: the held operand changes only at an accepted start
  p_opnd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(opnd_q));

  // R6: the serial bit is used only in the first W bit times
  p_take_window_r6: assert property (@(posedge clk) disable iff (rst)
    ctl_i.take |-> (seen_q && gap_q < 16'(W)));

  // R1: the sign-bit row is inverted exactly at the last serial bit
  p_negate_slot_r1: assert property (@(posedge clk) disable iff (rst)
    ctl_i.negate |-> (seen_q && gap_q == 16'(W - 1) && ctl_i.take));

  // R3: the row only advances inside its 2W bit times
  p_step_window_r3: assert property (@(posedge clk) disable iff (rst)
    ctl_i.step |-> (seen_q && gap_q < 16'(2 * W)));

  // R3: output is the row's product bit delayed by the alignment stages
  p_align_r3: assert property (@(posedge clk) disable iff (rst)
    (rsince_q >= 8'(W + 2)) |-> (prod_o == $past(lsb_i, W + 1)));

  // R8: output stays 0 once the last product window has passed
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!seen_q || gap_q >= 16'(LAT + 2 * W)) |-> !prod_o);

endmodule

bind spmul_serial spmul_serial_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .prod_o  (prod_o),
  .ctl_i   (ctl),
  .lsb_i   (s_w[0]),
  .opnd_q  (opnd_q)
);

// File: tb/spmul_serial_tb.sv
`timescale 1ns/1ps
module spmul_serial_tb;

  localparam int W    = 16;
  localparam int PW   = 2 * W;
  localparam int F    = 2 * W + 2;
  localparam int LAT  = W + 2;
  localparam int MAXF = 400;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         ser = 1'b0;
  logic [W-1:0] opnd = '0;
  logic         prod;

  always #2.5 clk = ~clk;

  spmul_serial #(.W(W)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .opnd_i  (opnd),
    .ser_i   (ser),
    .prod_o  (prod)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  logic [PW-1:0] exp_p [MAXF];
  logic [PW-1:0] got_p [MAXF];
  int            e0    [MAXF];
  string         tag   [MAXF];
  int            nf = 0;

  function automatic logic [PW-1:0] ref_mul(input logic signed [W-1:0] a,
                                            input logic signed [W-1:0] b);
    logic signed [PW-1:0] r;
    r = a * b;
    return r;
  endfunction

  task automatic check(input string req, input logic [PW-1:0] got,
                       input logic [PW-1:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, expv, cyc);
    end
  endtask

  // Output monitor: every clock, the expected bit comes from the frames issued
  always @(negedge clk) begin
    if (mon_on) begin
      logic expbit;
      bit   inwin;
      expbit = 1'b0;
      inwin  = 1'b0;
      for (int d = 1; d <= 2; d++) begin
        int fi;
        int k;
        fi = nf - d;
        if (fi >= 0) begin
          k = cyc - e0[fi] - LAT;
          if (k >= 0 && k < PW) begin
            inwin = 1'b1;
            expbit = exp_p[fi][k];
            got_p[fi][k] = prod;
            if (k == PW - 1) check(tag[fi], got_p[fi], exp_p[fi]);
          end
        end
      end
      if (inwin) check("R3 bit timing", PW'(prod), PW'(expbit));
      else       check("R8 idle output", PW'(prod), '0);
    end
  end

  // One frame; noisy_start adds stray starts, noisy_opnd scrambles the operand pin
  task automatic frame(input logic [W-1:0] a, input logic [W-1:0] b,
                       input string t, input bit noisy_start, input bit noisy_opnd);
    @(negedge clk);
    start = 1'b1;
    opnd  = a;
    ser   = 1'($urandom);
    e0[nf]    = cyc + 1;
    exp_p[nf] = ref_mul(a, b);
    got_p[nf] = '0;
    tag[nf]   = t;
    nf++;
    for (int k = 1; k < F; k++) begin
      @(negedge clk);
      start = noisy_start ? (($urandom % 3) == 0) : 1'b0;
      if (noisy_opnd) opnd = W'($urandom);
      ser = (k <= W) ? b[k-1] : 1'($urandom);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
      ser   = 1'($urandom);
      opnd  = W'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R8 output during reset", PW'(prod), '0);
    @(negedge clk);
    rst = 1'b0;
    mon_on = 1'b1;
    idle(8);

    // Sign corners, issued back to back
    frame(16'h8000, 16'h8000, "R9 min*min", 1'b0, 1'b0);
    frame(16'h8000, 16'h7FFF, "R9 min*max", 1'b0, 1'b0);
    frame(16'h7FFF, 16'h8000, "R9 max*min", 1'b0, 1'b0);
    frame(16'hFFFF, 16'hFFFF, "R1 -1*-1", 1'b0, 1'b0);
    frame(16'h0000, 16'h3039, "R1 zero operand", 1'b0, 1'b0);
    frame(16'h7FFF, 16'h7FFF, "R1 max*max", 1'b0, 1'b0);
    idle(3);
    // Bit sampling alignment: both end bits of the serial word
    frame(16'h0001, 16'h8001, "R2 serial sampling", 1'b0, 1'b0);
    idle(1);
    frame(16'hFFFF, 16'h0005, "R6 serial outside window", 1'b0, 1'b0);
    // Stray starts and operand changes during a frame
    frame(16'h1234, 16'hBEEF, "R5 start ignored", 1'b1, 1'b0);
    frame(16'hC001, 16'h7ACE, "R7 operand ignored", 1'b0, 1'b1);
    frame(16'h8000, 16'hFFFF, "R5 R7 combined", 1'b1, 1'b1);
    idle(2);
    // Back-to-back run
    for (int i = 0; i < 20; i++)
      frame(W'($urandom), W'($urandom), "R4 back to back", 1'b0, 1'b0);
    // Random mix of gaps and noise
    for (int i = 0; i < 150; i++) begin
      frame(W'($urandom), W'($urandom), "R1 random", 1'($urandom), 1'($urandom));
      idle($urandom % 4);
    end
    idle(LAT + PW + 6);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule